// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Controller

This block lets a clocked host read and write an external asynchronous static RAM of 16K words by 4 bits. The RAM has a shared bidirectional data bus and active-low strobes: one or two chip enables, a write enable and an output enable. The host issues one access at a time on a request/acknowledge port. The controller latches the address, write data and direction. It then sequences the strobes and steers the tristate data bus through `mem_dq_o` / `mem_dq_oe` / `mem_dq_i`, and stretches every phase over a configurable number of clock cycles so that the RAM's minimum pulse widths, cycle time and output float time are met.

The state machine has six states. `ST_STANDBY` holds every enable high, both strobes high and the bus released. On `req` with `ack` low it goes to `ST_SETUP`. `ST_SETUP` lasts one cycle: the address is already valid and the chip enable falls in this cycle. It then branches on the latched direction, to `ST_READ` or to `ST_WRITE`. `ST_READ` holds OE low for `RD_CYC` cycles and captures the bus on its last cycle, then goes to `ST_TURN`. `ST_TURN` deselects the chip and keeps the bus released for `TURN_CYC` cycles, then returns to `ST_STANDBY`. `ST_WRITE` holds WE low and drives the bus for `WR_CYC` cycles, then goes to `ST_WHOLD`. `ST_WHOLD` raises WE but keeps the chip selected and the bus driven for `WR_HOLD` cycles, then returns to `ST_STANDBY`. The acknowledge is registered. It is high in the first `ST_TURN` cycle after a read, and in the first `ST_STANDBY` cycle after a write.

The host holds `req` and its fields steady until it sees `ack`. With the defaults (`RD_CYC`=2, `WR_CYC`=2, `TURN_CYC`=1, `WR_HOLD`=1), a read takes 4 cycles from acceptance to its standby cycle and a write takes 4 cycles to its acknowledge.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: Out of reset, and whenever no access is in progress, both chip enables, WE and OE are high (1) and `mem_dq_oe` is low. Whenever the chip is deselected, WE and OE are high and the bus is not driven.
- R2: `mem_addr` carries the accepted address from the cycle in which the chip enable first goes low, and stays unchanged for as long as the enable stays low.
- R3: OE and WE are never low in the same cycle. OE goes low only during a read, and WE only during a write.
- R4: A read holds OE low (0) for exactly `RD_CYC` consecutive cycles after a one-cycle setup with the chip selected. `rdata` then equals the value present on `mem_dq_i` in the last of those cycles, even if earlier cycles carried different values.
- R5: A write holds WE low for exactly `WR_CYC` consecutive cycles, after a one-cycle setup. Throughout, `mem_dq_oe` is 1 and `mem_dq_o` equals the latched write data.
- R6: `mem_dq_oe` is high only while WE is low, or during the following `WR_HOLD` cycles in which the chip stays selected. It is never high while OE is low.
- R7: After OE rises, `mem_dq_oe` stays low for at least `TURN_CYC` cycles, and the chip stays deselected during those cycles.
- R8: `ack` is high for exactly one cycle per completed access. After a read it appears in the cycle following the last OE-low cycle. After a write it appears in the cycle after the last hold cycle.
- R9: A request is accepted only in standby while `ack` is low. A `req` still held high during the acknowledge cycle does not start a second access.
- R10: With `DUAL_CE`=1, `mem_ce2_n` always equals `mem_ce1_n`. With `DUAL_CE`=0, `mem_ce2_n` is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Host access request, held until `ack` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (14) | Word address |
| req_wdata | input | DATA_W (4) | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W (4) | Last captured read data |
| mem_addr | output | ADDR_W (14) | Address to the RAM |
| mem_ce1_n | output | 1 | First chip enable, active low |
| mem_ce2_n | output | 1 | Second chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_o | output | DATA_W (4) | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Tristate enable for `mem_dq_o` |
| mem_dq_i | input | DATA_W (4) | Data read from the RAM bus |

## Verification
On every cycle, assertions check the bus-safety rules. Deselection implies idle strobes and a released bus. OE and WE are never low together. The controller never drives while OE is low or inside the turnaround window after OE rises. The address stays stable under an active enable, and `ack` never lasts two cycles. Only the bench's scenarios can show the rest. Those cover the exact phase lengths and the cycle in which `ack` appears, and that read data is taken from the last OE-low cycle rather than an earlier one. They also show that written data lands at the right address and reads back, and that a request held through its acknowledge is not serviced twice.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_STANDBY = 3'd0,
        ST_SETUP   = 3'd1,
        ST_READ    = 3'd2,
        ST_TURN    = 3'd3,
        ST_WRITE   = 3'd4,
        ST_WHOLD   = 3'd5
    } ctl_state_e;

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign last = (cnt_q == (limit - CNT_W'(1)));

endmodule

// File: rtl/sram_dq_steer.sv
module sram_dq_steer #(
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic              drive,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_i,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wdata_q <= '0;
        end else if (load) begin
            wdata_q <= wdata_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (capture) begin
            rdata_q <= dq_i;
        end
    end

    assign dq_oe = drive;
    assign dq_o  = drive ? wdata_q : '0;
    assign rdata = rdata_q;

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 14,
    parameter int DATA_W   = 4,
    parameter int RD_CYC   = 2,
    parameter int WR_CYC   = 2,
    parameter int TURN_CYC = 1,
    parameter int WR_HOLD  = 1,
    parameter bit DUAL_CE  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce1_n,
    output logic              mem_ce2_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);

    localparam int MAX_CYC = max_of4(RD_CYC, WR_CYC, TURN_CYC, WR_HOLD);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    ctl_state_e        state_q, state_d;
    logic              accept;
    logic              restart;
    logic              last;
    logic [CNT_W-1:0]  limit;
    logic              write_q;
    logic [ADDR_W-1:0] addr_q;
    logic              ack_q;
    logic              ce_n, we_n, oe_n, drive, capture;

    assign accept  = (state_q == ST_STANDBY) && req && !ack_q;
    assign restart = (state_d != state_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STANDBY: if (accept) state_d = ST_SETUP;
            ST_SETUP:   state_d = write_q ? ST_WRITE : ST_READ;
            ST_READ:    if (last) state_d = ST_TURN;
            ST_TURN:    if (last) state_d = ST_STANDBY;
            ST_WRITE:   if (last) state_d = ST_WHOLD;
            ST_WHOLD:   if (last) state_d = ST_STANDBY;
            default:    state_d = ST_STANDBY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STANDBY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        limit = CNT_W'(1);
        unique case (state_q)
            ST_READ:  limit = CNT_W'(RD_CYC);
            ST_WRITE: limit = CNT_W'(WR_CYC);
            ST_WHOLD: limit = CNT_W'(WR_HOLD);
            ST_TURN:  limit = CNT_W'(TURN_CYC);
            default:  limit = CNT_W'(1);
        endcase
    end

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .limit   (limit),
        .last    (last)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            write_q <= 1'b0;
        end else if (accept) begin
            addr_q  <= req_addr;
            write_q <= req_write;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
        end else begin
            ack_q <= last && ((state_q == ST_READ) || (state_q == ST_WHOLD));
        end
    end

    always_comb begin
        ce_n    = 1'b1;
        we_n    = 1'b1;
        oe_n    = 1'b1;
        drive   = 1'b0;
        capture = 1'b0;
        unique case (state_q)
            ST_STANDBY: ;
            ST_SETUP:   ce_n = 1'b0;
            ST_READ: begin
                ce_n    = 1'b0;
                oe_n    = 1'b0;
                capture = last;
            end
            ST_TURN:    ;
            ST_WRITE: begin
                ce_n  = 1'b0;
                we_n  = 1'b0;
                drive = 1'b1;
            end
            ST_WHOLD: begin
                ce_n  = 1'b0;
                drive = 1'b1;
            end
            default: ;
        endcase
    end

    sram_dq_steer #(.DATA_W(DATA_W)) u_steer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .wdata_in (req_wdata),
        .drive    (drive),
        .capture  (capture),
        .dq_i     (mem_dq_i),
        .dq_o     (mem_dq_o),
        .dq_oe    (mem_dq_oe),
        .rdata    (rdata)
    );

    generate
        if (DUAL_CE) begin : g_dual
            assign mem_ce2_n = ce_n;
        end else begin : g_single
            assign mem_ce2_n = 1'b0;
        end
    endgenerate

    assign mem_ce1_n = ce_n;
    assign mem_we_n  = we_n;
    assign mem_oe_n  = oe_n;
    assign mem_addr  = addr_q;
    assign ack       = ack_q;

    logic [CNT_W-1:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= CNT_W'(TURN_CYC);
        end else if (!mem_oe_n) begin
            gap_q <= '0;
        end else if (gap_q < CNT_W'(TURN_CYC)) begin
            gap_q <= gap_q + CNT_W'(1);
        end
    end

    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce1_n |-> (mem_we_n && mem_oe_n && !mem_dq_oe)); // R1

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce1_n && $past(!mem_ce1_n)) |-> $stable(mem_addr)); // R2

    AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n)); // R3

    AST_WE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_dq_oe); // R5

    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n); // R6

    AST_TURN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (gap_q >= CNT_W'(TURN_CYC))); // R7

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack); // R8

endmodule

// File: tb/tb_sram_strobe_ctrl.sv
module tb_sram_strobe_ctrl;

    localparam int AW = 14;
    localparam int DW = 4;
    localparam int RD = 2;
    localparam int WR = 2;
    localparam int TN = 1;
    localparam int HD = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          req = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          ack;
    logic [DW-1:0] rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_ce1_n, mem_ce2_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_o;
    logic [DW-1:0] mem_dq_i;

    logic [DW-1:0] ram [0:(1<<AW)-1];
    int oe_run = 0;
    int checks = 0;
    int fails  = 0;

    sram_strobe_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .RD_CYC(RD), .WR_CYC(WR),
        .TURN_CYC(TN), .WR_HOLD(HD), .DUAL_CE(1'b1)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .ack(ack), .rdata(rdata),
        .mem_addr(mem_addr), .mem_ce1_n(mem_ce1_n), .mem_ce2_n(mem_ce2_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    // RAM model: data becomes valid only once OE has been low for RD cycles
    always @(negedge clk) begin
        if (!mem_oe_n) oe_run <= oe_run + 1;
        else           oe_run <= 0;
    end

    always_comb begin
        if (!mem_ce1_n && !mem_oe_n && mem_we_n)
            mem_dq_i = (oe_run >= RD) ? ram[mem_addr] : ~ram[mem_addr];
        else
            mem_dq_i = '0;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // vector bits: {ce_n, we_n, oe_n, dq_oe, ack}
    task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input bit hold_req);
        int exp_q[$];
        string tag_q[$];
        logic [DW-1:0] expect_rd;
        bit drop_next;
        expect_rd = ram[a];
        drop_next = 1'b0;
        @(negedge clk);
        req = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        exp_q.push_back(5'b01100); tag_q.push_back("R2");
        if (!wr) begin
            for (int i = 0; i < RD; i++) begin exp_q.push_back(5'b01000); tag_q.push_back("R4"); end
            for (int i = 0; i < TN; i++) begin
                exp_q.push_back(i == 0 ? 5'b11101 : 5'b11100); tag_q.push_back("R7");
            end
            exp_q.push_back(5'b11100); tag_q.push_back("R1");
        end else begin
            for (int i = 0; i < WR; i++) begin exp_q.push_back(5'b00110); tag_q.push_back("R5"); end
            for (int i = 0; i < HD; i++) begin exp_q.push_back(5'b01110); tag_q.push_back("R6"); end
            exp_q.push_back(5'b11101); tag_q.push_back("R8");
            exp_q.push_back(5'b11100); tag_q.push_back("R9");
        end
        foreach (exp_q[k]) begin
            @(negedge clk);
            chk(tag_q[k], int'({mem_ce1_n, mem_we_n, mem_oe_n, mem_dq_oe, ack}), exp_q[k]);
            chk("R10", int'(mem_ce2_n), int'(mem_ce1_n));
            chk("R3", int'(!mem_oe_n && !mem_we_n), 0);
            if (!mem_ce1_n) chk("R2", int'(mem_addr), int'(a));
            if (mem_dq_oe) chk("R5", int'(mem_dq_o), int'(d));
            if (ack && !wr) chk("R4", int'(rdata), int'(expect_rd));
            if (drop_next) req = 1'b0;
            if (ack) begin
                if (hold_req) drop_next = 1'b1;
                else req = 1'b0;
            end
        end
        req = 1'b0;
        if (wr) ram[a] = d;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < (1 << AW); i++) ram[i] = DW'((i ^ (i >> 4)) & 'hF);
        repeat (2) @(negedge clk);
        // R1: standby during and after reset
        chk("R1", int'({mem_ce1_n, mem_ce2_n, mem_we_n, mem_oe_n, mem_dq_oe, ack}), 6'b111100);
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R1", int'({mem_ce1_n, mem_ce2_n, mem_we_n, mem_oe_n, mem_dq_oe, ack}), 6'b111100);
        end
        access(1'b0, 14'h0012, 4'h0, 1'b0);
        access(1'b1, 14'h0000, 4'hA, 1'b0);
        access(1'b1, 14'h3FFF, 4'h5, 1'b1);
        access(1'b0, 14'h0000, 4'h0, 1'b0);
        access(1'b0, 14'h3FFF, 4'h0, 1'b0);
        access(1'b1, 14'h1234, 4'hF, 1'b0);
        access(1'b0, 14'h1234, 4'h0, 1'b0);
        access(1'b1, 14'h2AAA, 4'h0, 1'b1);
        access(1'b0, 14'h2AAA, 4'h0, 1'b0);
        access(1'b0, 14'h0777, 4'h0, 1'b0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R1", int'({mem_ce1_n, mem_we_n, mem_oe_n, mem_dq_oe, ack}), 5'b11100);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule